// File: doc/BRIEF.md
# Read Tag and Completion-Credit Manager

This block sits between several read-request sources and the transmit side of a PCIe transaction layer. It hands out read tags and keeps the application's account of completion receive-buffer space. That space is counted in two kinds of credit: header credit (one per completion TLP) and data credit (one per 16 bytes of payload). A source raises a request that states the header and data credit its read will need. The block grants a tag in the same cycle, but only when a tag is free and enough unreserved credit remains. Credit is debited when the formatted read request actually leaves. It is returned as completions come back.

Each tag records its owning source, its state, the cycle it was sent, and the credit still owed to it. A background scan visits one tag per clock. If a sent tag has waited longer than a programmable number of cycles, the scan frees it, returns its remaining credit, sends a termination strobe to the owning source and pulses a completion-timeout error. Completions that arrive for a tag that is not currently awaiting data are discarded and flagged. This includes completions for a tag that has timed out.

The credit budget is a static input. Bits [7:0] hold the header credit and bits [19:8] hold the data credit.

Top module: `rd_tag_credit_mgr`

## Requirements
- R1: After reset, no request is granted without a valid, no termination strobe, error or drop flag is raised, and the available credit equals the configured budget.
- R2: A request is granted only if at least one tag is free and both its declared header and data credit are no larger than the unreserved credit. Otherwise ready stays low.
- R3: Among valid requesters, the lowest index wins. At most one ready bit is high, and the granted tag is the lowest-numbered free tag.
- R4: A grant leaves the available credit unchanged. Sending a granted tag lowers available header and data credit by the amounts declared at its grant.
- R5: Credit declared by granted but not yet sent tags is reserved and counts against later grants.
- R6: A non-final completion for a sent tag returns one header credit, if the tag still owes one, and returns data credit equal to the smaller of the completion's data credit and what the tag still owes.
- R7: A final completion returns all credit the tag still owes and frees the tag for reuse.
- R8: A completion for a tag that is free, timed out, or granted but not sent is dropped. One cycle later the drop flag pulses, and the credit is not changed.
- R9: A sent tag that receives no final completion is timed out between T and T+NUM_TAGS+2 cycles after sending, where T is the timeout threshold. At that point its remaining credit is returned, the tag is freed, the owner's termination bit pulses with the tag number, and the error pulses.
- R10: A send debit and a completion return in the same cycle are both applied in that cycle.
- R11: Available credit never exceeds the budget and never wraps below zero.
- R12: The budget input carries header credit in bits [7:0] and data credit in bits [19:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_budget | input | HDR_W+DAT_W | Static credit budget: header [7:0], data [19:8] |
| cfg_timeout | input | TS_W | Timeout threshold in cycles |
| req_valid | input | NUM_REQ | Per-requester request valid |
| req_cplh | input | NUM_REQ*HDR_W | Declared header credit per requester |
| req_cpld | input | NUM_REQ*DAT_W | Declared data credit per requester |
| req_ready | output | NUM_REQ | Grant, one-hot |
| gnt_tag | output | TAG_W | Tag granted this cycle |
| tx_sent | input | 1 | Read request with tx_tag has left |
| tx_tag | input | TAG_W | Tag of the sent request |
| cpl_valid | input | 1 | Completion arrived |
| cpl_tag | input | TAG_W | Completion tag |
| cpl_cpld | input | DAT_W | Data credit carried by the completion |
| cpl_last | input | 1 | Final completion for the tag |
| cpl_drop | output | 1 | Previous cycle's completion was discarded |
| term_valid | output | NUM_REQ | Per-requester timeout termination strobe |
| term_tag | output | TAG_W | Tag that timed out |
| cto_err | output | 1 | Completion-timeout error pulse |
| avail_cplh | output | HDR_W | Header credit not yet debited |
| avail_cpld | output | DAT_W | Data credit not yet debited |

## Verification
The debit taken when one tag is sent and the credit returned by a completion for a different tag can fall in the same clock edge. The bench provokes this by driving `tx_sent` for a freshly granted tag together with a partial completion on another sent tag. It then checks that the available header and data credit equal the old value minus the declared amounts plus the returned amounts. A completion on the tag the timeout scan is examining also collides: the completion is given precedence, and the tag is revisited on a later lap.

// File: rtl/rtcm_pkg.sv
`timescale 1ns/1ps
package rtcm_pkg;
  typedef enum logic [1:0] {
    TAG_FREE    = 2'd0,
    TAG_GRANTED = 2'd1,
    TAG_WAITING = 2'd2
  } tag_state_e;
endpackage

// File: rtl/rtcm_tag_pick.sv
`timescale 1ns/1ps
module rtcm_tag_pick #(
  parameter int NUM_TAGS = 32,
  parameter int NUM_REQ  = 2,
  parameter int HDR_W    = 8,
  parameter int DAT_W    = 12,
  localparam int TAG_W   = $clog2(NUM_TAGS),
  localparam int REQ_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic [NUM_TAGS-1:0]      free_vec,
  input  logic [NUM_REQ-1:0]       req_valid,
  input  logic [NUM_REQ*HDR_W-1:0] req_cplh,
  input  logic [NUM_REQ*DAT_W-1:0] req_cpld,
  input  logic [HDR_W-1:0]         room_h,
  input  logic [DAT_W-1:0]         room_d,
  output logic [NUM_REQ-1:0]       req_ready,
  output logic                     fire,
  output logic [REQ_W-1:0]         win_idx,
  output logic [HDR_W-1:0]         win_h,
  output logic [DAT_W-1:0]         win_d,
  output logic [TAG_W-1:0]         pick_tag
);
  logic any_req, any_free, fits;

  // lowest-index requester wins
  always_comb begin
    any_req = 1'b0;
    win_idx = '0;
    for (int i = NUM_REQ - 1; i >= 0; i--) begin
      if (req_valid[i]) begin
        any_req = 1'b1;
        win_idx = REQ_W'(i);
      end
    end
  end

  // lowest-numbered free tag
  always_comb begin
    any_free = 1'b0;
    pick_tag = '0;
    for (int t = NUM_TAGS - 1; t >= 0; t--) begin
      if (free_vec[t]) begin
        any_free = 1'b1;
        pick_tag = TAG_W'(t);
      end
    end
  end

  assign win_h = req_cplh[win_idx*HDR_W +: HDR_W];
  assign win_d = req_cpld[win_idx*DAT_W +: DAT_W];
  assign fits  = (win_h <= room_h) && (win_d <= room_d);
  assign fire  = any_req && any_free && fits;

  always_comb begin
    req_ready = '0;
    if (fire) req_ready[win_idx] = 1'b1;
  end
endmodule

// File: rtl/rtcm_credit_ledger.sv
`timescale 1ns/1ps
module rtcm_credit_ledger #(
  parameter int HDR_W = 8,
  parameter int DAT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [HDR_W-1:0] budget_h,
  input  logic [DAT_W-1:0] budget_d,
  input  logic             resv_en,
  input  logic [HDR_W-1:0] resv_h,
  input  logic [DAT_W-1:0] resv_d,
  input  logic             send_en,
  input  logic [HDR_W-1:0] send_h,
  input  logic [DAT_W-1:0] send_d,
  input  logic [HDR_W-1:0] ret_h,
  input  logic [DAT_W-1:0] ret_d,
  output logic [HDR_W-1:0] avail_h,
  output logic [DAT_W-1:0] avail_d,
  output logic [HDR_W-1:0] room_h,
  output logic [DAT_W-1:0] room_d
);
  logic [HDR_W-1:0] used_h_q, used_h_n, held_h_q, held_h_n;
  logic [DAT_W-1:0] used_d_q, used_d_n, held_d_q, held_d_n;
  logic [HDR_W-1:0] deb_h;
  logic [DAT_W-1:0] deb_d;
  logic             used_en, held_en;

  assign deb_h = send_en ? send_h : '0;
  assign deb_d = send_en ? send_d : '0;

  always_comb begin
    used_en  = send_en || (ret_h != '0) || (ret_d != '0);
    held_en  = send_en || resv_en;
    used_h_n = used_h_q + deb_h - ret_h;
    used_d_n = used_d_q + deb_d - ret_d;
    held_h_n = held_h_q + (resv_en ? resv_h : '0) - deb_h;
    held_d_n = held_d_q + (resv_en ? resv_d : '0) - deb_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_h_q <= '0;
      used_d_q <= '0;
    end else if (used_en) begin
      used_h_q <= used_h_n;
      used_d_q <= used_d_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_h_q <= '0;
      held_d_q <= '0;
    end else if (held_en) begin
      held_h_q <= held_h_n;
      held_d_q <= held_d_n;
    end
  end

  assign avail_h = budget_h - used_h_q;
  assign avail_d = budget_d - used_d_q;
  assign room_h  = avail_h - held_h_q;
  assign room_d  = avail_d - held_d_q;
endmodule

// File: rtl/rtcm_timeout_scan.sv
`timescale 1ns/1ps
module rtcm_timeout_scan #(
  parameter int NUM_TAGS = 32,
  parameter int TS_W     = 16,
  localparam int TAG_W   = $clog2(NUM_TAGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TS_W-1:0]  cfg_timeout,
  input  logic             sel_live,
  input  logic [TS_W-1:0]  sel_ts,
  input  logic             hold,
  output logic [TAG_W-1:0] scan_ptr,
  output logic [TS_W-1:0]  now_ts,
  output logic             expire
);
  logic [TAG_W-1:0] ptr_q, ptr_n;
  logic [TS_W-1:0]  now_q, age;

  assign ptr_n = (ptr_q == TAG_W'(NUM_TAGS - 1)) ? '0 : ptr_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      now_q <= '0;
    end else begin
      ptr_q <= ptr_n;
      now_q <= now_q + 1'b1;
    end
  end

  assign age      = now_q - sel_ts;
  assign expire   = sel_live && !hold && (age >= cfg_timeout);
  assign scan_ptr = ptr_q;
  assign now_ts   = now_q;
endmodule

// File: rtl/rd_tag_credit_mgr.sv
`timescale 1ns/1ps
module rd_tag_credit_mgr
  import rtcm_pkg::*;
#(
  parameter int NUM_TAGS = 32,
  parameter int NUM_REQ  = 2,
  parameter int HDR_W    = 8,
  parameter int DAT_W    = 12,
  parameter int TS_W     = 16,
  localparam int TAG_W   = $clog2(NUM_TAGS),
  localparam int REQ_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [HDR_W+DAT_W-1:0]   cfg_budget,
  input  logic [TS_W-1:0]          cfg_timeout,
  input  logic [NUM_REQ-1:0]       req_valid,
  input  logic [NUM_REQ*HDR_W-1:0] req_cplh,
  input  logic [NUM_REQ*DAT_W-1:0] req_cpld,
  output logic [NUM_REQ-1:0]       req_ready,
  output logic [TAG_W-1:0]         gnt_tag,
  input  logic                     tx_sent,
  input  logic [TAG_W-1:0]         tx_tag,
  input  logic                     cpl_valid,
  input  logic [TAG_W-1:0]         cpl_tag,
  input  logic [DAT_W-1:0]         cpl_cpld,
  input  logic                     cpl_last,
  output logic                     cpl_drop,
  output logic [NUM_REQ-1:0]       term_valid,
  output logic [TAG_W-1:0]         term_tag,
  output logic                     cto_err,
  output logic [HDR_W-1:0]         avail_cplh,
  output logic [DAT_W-1:0]         avail_cpld
);
  // R12: header budget in the low byte, data budget above it
  logic [HDR_W-1:0] budget_h;
  logic [DAT_W-1:0] budget_d;
  assign budget_h = cfg_budget[HDR_W-1:0];
  assign budget_d = cfg_budget[HDR_W +: DAT_W];

  tag_state_e       st_q  [NUM_TAGS];
  tag_state_e       st_n  [NUM_TAGS];
  logic [REQ_W-1:0] own_q [NUM_TAGS];
  logic [REQ_W-1:0] own_n [NUM_TAGS];
  logic [HDR_W-1:0] oh_q  [NUM_TAGS];
  logic [HDR_W-1:0] oh_n  [NUM_TAGS];
  logic [DAT_W-1:0] od_q  [NUM_TAGS];
  logic [DAT_W-1:0] od_n  [NUM_TAGS];
  logic [TS_W-1:0]  ts_q  [NUM_TAGS];
  logic [TS_W-1:0]  ts_n  [NUM_TAGS];
  logic [NUM_TAGS-1:0] free_vec;

  genvar g;
  generate
    for (g = 0; g < NUM_TAGS; g++) begin : g_free
      assign free_vec[g] = (st_q[g] == TAG_FREE);
    end
  endgenerate

  // grant path
  logic             fire;
  logic [REQ_W-1:0] win_idx;
  logic [HDR_W-1:0] win_h, room_h;
  logic [DAT_W-1:0] win_d, room_d;

  rtcm_tag_pick #(
    .NUM_TAGS(NUM_TAGS), .NUM_REQ(NUM_REQ), .HDR_W(HDR_W), .DAT_W(DAT_W)
  ) u_pick (
    .free_vec (free_vec),
    .req_valid(req_valid),
    .req_cplh (req_cplh),
    .req_cpld (req_cpld),
    .room_h   (room_h),
    .room_d   (room_d),
    .req_ready(req_ready),
    .fire     (fire),
    .win_idx  (win_idx),
    .win_h    (win_h),
    .win_d    (win_d),
    .pick_tag (gnt_tag)
  );

  // send path: only a granted tag may be sent
  logic send_ok;
  assign send_ok = tx_sent && (st_q[tx_tag] == TAG_GRANTED);

  // completion path: only a sent tag accepts data
  logic             cpl_hit;
  logic [HDR_W-1:0] cpl_ret_h;
  logic [DAT_W-1:0] cpl_ret_d;
  assign cpl_hit = cpl_valid && (st_q[cpl_tag] == TAG_WAITING);

  always_comb begin
    cpl_ret_h = '0;
    cpl_ret_d = '0;
    if (cpl_hit) begin
      if (cpl_last) begin
        cpl_ret_h = oh_q[cpl_tag];
        cpl_ret_d = od_q[cpl_tag];
      end else begin
        cpl_ret_h = (oh_q[cpl_tag] != '0) ? HDR_W'(1) : '0;
        cpl_ret_d = (cpl_cpld < od_q[cpl_tag]) ? cpl_cpld : od_q[cpl_tag];
      end
    end
  end

  // timeout scan; a completion on the scanned tag takes precedence
  logic [TAG_W-1:0] scan_ptr;
  logic [TS_W-1:0]  now_ts;
  logic             expire, scan_hold;
  logic [HDR_W-1:0] to_ret_h;
  logic [DAT_W-1:0] to_ret_d;
  assign scan_hold = cpl_valid && (cpl_tag == scan_ptr);

  rtcm_timeout_scan #(.NUM_TAGS(NUM_TAGS), .TS_W(TS_W)) u_scan (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_timeout(cfg_timeout),
    .sel_live   (st_q[scan_ptr] == TAG_WAITING),
    .sel_ts     (ts_q[scan_ptr]),
    .hold       (scan_hold),
    .scan_ptr   (scan_ptr),
    .now_ts     (now_ts),
    .expire     (expire)
  );

  assign to_ret_h = expire ? oh_q[scan_ptr] : '0;
  assign to_ret_d = expire ? od_q[scan_ptr] : '0;

  rtcm_credit_ledger #(.HDR_W(HDR_W), .DAT_W(DAT_W)) u_ledger (
    .clk     (clk),
    .rst_n   (rst_n),
    .budget_h(budget_h),
    .budget_d(budget_d),
    .resv_en (fire),
    .resv_h  (win_h),
    .resv_d  (win_d),
    .send_en (send_ok),
    .send_h  (oh_q[tx_tag]),
    .send_d  (od_q[tx_tag]),
    .ret_h   (cpl_ret_h + to_ret_h),
    .ret_d   (cpl_ret_d + to_ret_d),
    .avail_h (avail_cplh),
    .avail_d (avail_cpld),
    .room_h  (room_h),
    .room_d  (room_d)
  );

  // tag table next state
  always_comb begin
    for (int t = 0; t < NUM_TAGS; t++) begin
      st_n[t]  = st_q[t];
      own_n[t] = own_q[t];
      oh_n[t]  = oh_q[t];
      od_n[t]  = od_q[t];
      ts_n[t]  = ts_q[t];
      if (fire && gnt_tag == TAG_W'(t)) begin
        st_n[t]  = TAG_GRANTED;
        own_n[t] = win_idx;
        oh_n[t]  = win_h;
        od_n[t]  = win_d;
      end
      if (send_ok && tx_tag == TAG_W'(t)) begin
        st_n[t] = TAG_WAITING;
        ts_n[t] = now_ts;
      end
      if (cpl_hit && cpl_tag == TAG_W'(t)) begin
        oh_n[t] = oh_q[t] - cpl_ret_h;
        od_n[t] = od_q[t] - cpl_ret_d;
        if (cpl_last) st_n[t] = TAG_FREE;
      end
      if (expire && scan_ptr == TAG_W'(t)) begin
        st_n[t] = TAG_FREE;
        oh_n[t] = '0;
        od_n[t] = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < NUM_TAGS; t++) begin
        st_q[t]  <= TAG_FREE;
        own_q[t] <= '0;
        oh_q[t]  <= '0;
        od_q[t]  <= '0;
        ts_q[t]  <= '0;
      end
    end else begin
      for (int t = 0; t < NUM_TAGS; t++) begin
        st_q[t]  <= st_n[t];
        own_q[t] <= own_n[t];
        oh_q[t]  <= oh_n[t];
        od_q[t]  <= od_n[t];
        ts_q[t]  <= ts_n[t];
      end
    end
  end

  // registered event outputs
  logic [NUM_REQ-1:0] term_n;
  always_comb begin
    term_n = '0;
    if (expire) term_n[own_q[scan_ptr]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      term_valid <= '0;
      term_tag   <= '0;
      cto_err    <= 1'b0;
      cpl_drop   <= 1'b0;
    end else begin
      term_valid <= term_n;
      term_tag   <= scan_ptr;
      cto_err    <= expire;
      cpl_drop   <= cpl_valid && !cpl_hit;
    end
  end
endmodule

// File: rtl/rtcm_checker.sv
`timescale 1ns/1ps
module rtcm_checker #(
  parameter int NUM_REQ = 2,
  parameter int HDR_W   = 8,
  parameter int DAT_W   = 12
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [HDR_W+DAT_W-1:0]   cfg_budget,
  input logic [NUM_REQ-1:0]       req_ready,
  input logic [NUM_REQ*HDR_W-1:0] req_cplh,
  input logic [NUM_REQ*DAT_W-1:0] req_cpld,
  input logic                     tx_sent,
  input logic                     cpl_valid,
  input logic [NUM_REQ-1:0]       term_valid,
  input logic                     cto_err,
  input logic [HDR_W-1:0]         avail_cplh,
  input logic [DAT_W-1:0]         avail_cpld
);
  logic fit_ok;
  always_comb begin
    fit_ok = 1'b1;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (req_ready[i] && (req_cplh[i*HDR_W +: HDR_W] > avail_cplh ||
                           req_cpld[i*DAT_W +: DAT_W] > avail_cpld))
        fit_ok = 1'b0;
    end
  end

  AST_WITHIN_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
    (avail_cplh <= cfg_budget[HDR_W-1:0]) && (avail_cpld <= cfg_budget[HDR_W +: DAT_W])); // R11
  AST_READY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready)); // R3
  AST_GRANT_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_ready) |-> fit_ok); // R2
  AST_QUIET_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_sent && !cpl_valid) ##1 (term_valid == '0) |-> $stable(avail_cplh) && $stable(avail_cpld)); // R4
  AST_TERM_WITH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (|term_valid) |-> (cto_err && $onehot(term_valid))); // R9
endmodule

bind rd_tag_credit_mgr rtcm_checker #(
  .NUM_REQ(NUM_REQ), .HDR_W(HDR_W), .DAT_W(DAT_W)
) u_rtcm_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_budget(cfg_budget),
  .req_ready (req_ready),
  .req_cplh  (req_cplh),
  .req_cpld  (req_cpld),
  .tx_sent   (tx_sent),
  .cpl_valid (cpl_valid),
  .term_valid(term_valid),
  .cto_err   (cto_err),
  .avail_cplh(avail_cplh),
  .avail_cpld(avail_cpld)
);

// File: tb/rd_tag_credit_mgr_bench.sv
`timescale 1ns/1ps
module rd_tag_credit_mgr_bench;
  localparam int NT = 4, NR = 2, HW = 8, DW = 12, TW = 16;
  localparam int BH = 6, BD = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [HW+DW-1:0] cfg_budget;
  logic [TW-1:0]    cfg_timeout;
  logic [NR-1:0]    req_valid;
  logic [NR*HW-1:0] req_cplh;
  logic [NR*DW-1:0] req_cpld;
  logic [NR-1:0]    req_ready;
  logic [1:0]       gnt_tag, tx_tag, cpl_tag, term_tag;
  logic             tx_sent, cpl_valid, cpl_last, cpl_drop, cto_err;
  logic [DW-1:0]    cpl_cpld;
  logic [NR-1:0]    term_valid;
  logic [HW-1:0]    avail_cplh;
  logic [DW-1:0]    avail_cpld;

  rd_tag_credit_mgr #(.NUM_TAGS(NT), .NUM_REQ(NR), .HDR_W(HW), .DAT_W(DW), .TS_W(TW))
  u_rd_tag_credit_mgr (
    .clk(clk), .rst_n(rst_n), .cfg_budget(cfg_budget), .cfg_timeout(cfg_timeout),
    .req_valid(req_valid), .req_cplh(req_cplh), .req_cpld(req_cpld),
    .req_ready(req_ready), .gnt_tag(gnt_tag), .tx_sent(tx_sent), .tx_tag(tx_tag),
    .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_cpld(cpl_cpld), .cpl_last(cpl_last),
    .cpl_drop(cpl_drop), .term_valid(term_valid), .term_tag(term_tag),
    .cto_err(cto_err), .avail_cplh(avail_cplh), .avail_cpld(avail_cpld)
  );

  int n_run = 0, n_fail = 0;
  int exp_h, exp_d;
  bit finished = 0;

  task automatic chk(input string rq, input int act, input int expv);
    n_run++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, expv);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_req(input int r, input int h, input int d);
    req_cplh[r*HW +: HW] = HW'(h);
    req_cpld[r*DW +: DW] = DW'(d);
  endtask

  task automatic grant(input int r, input int h, input int d, input int etag, input string rq);
    set_req(r, h, d);
    req_valid = NR'(1 << r);
    #0.1;
    chk({rq, " ready"}, req_ready, 1 << r);
    chk({rq, " tag"}, gnt_tag, etag);
    step();
    req_valid = '0;
  endtask

  task automatic send(input int t);
    tx_sent = 1'b1; tx_tag = 2'(t);
    step();
    tx_sent = 1'b0;
  endtask

  task automatic cpl(input int t, input int d, input bit last);
    cpl_valid = 1'b1; cpl_tag = 2'(t); cpl_cpld = DW'(d); cpl_last = last;
    step();
    cpl_valid = 1'b0; cpl_last = 1'b0;
  endtask

  task automatic chk_avail(input string rq);
    chk({rq, " avail_cplh"}, avail_cplh, exp_h);
    chk({rq, " avail_cpld"}, avail_cpld, exp_d);
  endtask

  initial begin
    cfg_budget = {DW'(BD), HW'(BH)};
    cfg_timeout = 16'd1000;
    req_valid = '0; req_cplh = '0; req_cpld = '0;
    tx_sent = 0; tx_tag = 0; cpl_valid = 0; cpl_tag = 0; cpl_cpld = 0; cpl_last = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();

    // R1 / R12: reset state, budget fields
    exp_h = BH; exp_d = BD;
    chk_avail("R1 R12 reset");
    chk("R1 ready", req_ready, 0);
    chk("R1 term", term_valid, 0);
    chk("R1 err", cto_err, 0);
    chk("R1 drop", cpl_drop, 0);

    // R2: sweep declared credit against an empty ledger
    req_valid = 2'b01;
    for (int h = 0; h <= BH + 1; h++) begin
      for (int k = 0; k < 3; k++) begin
        int d;
        d = (k == 0) ? 0 : (k == 1) ? BD : BD + 1;
        set_req(0, h, d);
        #0.1;
        chk("R2 sweep", req_ready[0], (h <= BH && d <= BD) ? 1 : 0);
      end
    end
    req_valid = '0;
    @(negedge clk);

    // R3: both request, lowest index wins, lowest tag
    set_req(0, 1, 2); set_req(1, 1, 3);
    req_valid = 2'b11;
    #0.1;
    chk("R3 priority", req_ready, 2'b01);
    chk("R3 tag", gnt_tag, 0);
    step();
    req_valid = '0;
    chk_avail("R4 grant no move");
    grant(1, 1, 3, 1, "R3 second");

    // R4: send debits declared amount
    send(0);
    exp_h = 5; exp_d = 18;
    chk_avail("R4 send");

    // R5: tag1 reserved but unsent: room h=4 d=15
    req_valid = 2'b01;
    set_req(0, 4, 15); #0.1; chk("R5 fits", req_ready[0], 1);
    set_req(0, 5, 15); #0.1; chk("R5 hdr over", req_ready[0], 0);
    set_req(0, 4, 16); #0.1; chk("R5 dat over", req_ready[0], 0);
    req_valid = '0;
    @(negedge clk);
    send(1);
    exp_h = 4; exp_d = 15;
    chk_avail("R4 send tag1");

    // R6: partial completion on tag0 (owes h1 d2)
    cpl(0, 1, 0);
    exp_h = 5; exp_d = 16;
    chk_avail("R6 partial");
    chk("R6 no drop", cpl_drop, 0);

    // R10: send tag2 and partial completion on tag1 in one cycle
    grant(0, 2, 4, 2, "R10 grant");
    tx_sent = 1; tx_tag = 2;
    cpl_valid = 1; cpl_tag = 1; cpl_cpld = 2; cpl_last = 0;
    step();
    tx_sent = 0; cpl_valid = 0;
    exp_h = 4; exp_d = 14;
    chk_avail("R10 same cycle");

    // R7: final completions return remainder and free tags
    cpl(1, 0, 1);
    exp_h = 4; exp_d = 15;
    chk_avail("R7 final tag1");
    set_req(0, 0, 0); req_valid = 2'b01; #0.1;
    chk("R7 tag reuse", gnt_tag, 1);
    req_valid = '0;
    @(negedge clk);
    cpl(0, 1, 1);
    exp_h = 4; exp_d = 16;
    chk_avail("R7 final tag0");

    // R8: completion on a free tag
    cpl(0, 3, 0);
    chk("R8 free drop", cpl_drop, 1);
    chk_avail("R8 free no change");

    // R2: tag exhaustion (tag2 in flight, take 0,1,3)
    grant(0, 0, 0, 0, "R2 fill0");
    grant(1, 0, 0, 1, "R2 fill1");
    grant(0, 0, 0, 3, "R2 fill3");
    set_req(0, 0, 0); req_valid = 2'b01; #0.1;
    chk("R2 no free tag", req_ready, 0);
    req_valid = '0;
    @(negedge clk);
    // R8: completion on a granted, unsent tag
    cpl(3, 1, 1);
    chk("R8 unsent drop", cpl_drop, 1);
    chk_avail("R8 unsent no change");
    send(0); send(1); send(3);
    cpl(0, 0, 1); cpl(1, 0, 1); cpl(3, 0, 1);
    cpl(2, 4, 1);
    exp_h = BH; exp_d = BD;
    chk_avail("R7 all returned");

    // R9: timeout
    cfg_timeout = 16'd20;
    grant(1, 1, 5, 0, "R9 grant");
    send(0);
    exp_h = 5; exp_d = 15;
    chk_avail("R9 debit");
    begin
      int waited = 0;
      bit seen = 0;
      for (int c = 1; c <= 60 && !seen; c++) begin
        step();
        if (term_valid != 0) begin
          seen = 1; waited = c;
        end
      end
      chk("R9 seen", seen, 1);
      chk("R9 not early", waited >= 20, 1);
      chk("R9 not late", waited <= 20 + NT + 2, 1);
      chk("R9 owner", term_valid, 2'b10);
      chk("R9 tag", term_tag, 0);
      chk("R9 err", cto_err, 1);
      exp_h = BH; exp_d = BD;
      chk_avail("R9 reclaimed");
    end
    step();
    chk("R9 err pulse", cto_err, 0);

    // R8: completion after timeout is dropped
    cpl(0, 2, 0);
    chk("R8 timed-out drop", cpl_drop, 1);
    chk_avail("R8 timed-out no change");

    // R9: freed tag reusable, new completions accepted
    cfg_timeout = 16'd1000;
    grant(0, 1, 2, 0, "R9 reuse");
    send(0);
    cpl(0, 1, 0);
    chk("R9 reuse accepted", cpl_drop, 0);
    exp_h = BH; exp_d = BD - 1;
    chk_avail("R9 reuse partial");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    finished = 1;
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule